// File: doc/BRIEF.md
# Transmit Input Phase-Align Stage

This block is the per-channel front end of a serial-link transmitter. Every input clock cycle it captures one 10-bit parallel word, made of an 8-bit data byte and a 2-bit control field, and delivers it to the channel's internal character clock domain. Two clocking arrangements are supported. In the first, the external transmit clock times the input register, and a small asynchronous FIFO absorbs the unknown but fixed phase offset between that clock and the character clock. In the second, the full-rate reference clock, which is the character clock itself, times the input register, and the FIFO is skipped.

In buffered operation the read side centres the FIFO before it delivers anything. After reset, or after a recentre request, it shows a fixed idle character until its view of the FIFO holds a set number of entries. If the FIFO later runs dry or overruns, a sticky error flag is raised, and a recentre request clears it. A separate mode input says whether the word goes on to an 8b/10b encoder as data plus control qualifiers, or is already a finished 10-bit line character. The word travels unchanged in both cases; only the accompanying flag differs.

Top module: `tx_phase_align`

## Requirements
- R1: While `rst` is high, `out_live` and `out_err` are 0 and `out_char` shows the idle character 10'h17C.
- R2: `out_char[9:8]` carries the captured control field and `out_char[7:0]` the captured data byte, unchanged. `out_raw` follows `enc_off` one character-clock cycle later, where 1 means a pre-encoded 10-bit character and 0 means data plus encoder qualifiers.
- R3: When `sel_refclk`=0, or when `rate_half`=1, words are captured on `clk_tx`. With `clk_tx` and `clk_char` at equal frequency and any phase, every captured word appears on `out_char` exactly once and in capture order, with `out_live` high.
- R4: After reset, `out_live` stays 0 and `out_char` stays idle until the read side sees at least CENTRE (2) entries. The first live word is the first word captured after reset.
- R5: In buffered mode, if the read side finds the FIFO empty while running, `out_err` is set to 1 and `out_live` drops to 0. `out_err` then stays 1 until a recentre.
- R6: In buffered mode, if the read side sees more than DEPTH (8) unread entries, `out_err` is set to 1 and stays set until a recentre.
- R7: A one-cycle `recentre` pulse in buffered mode has three effects on the next character-clock cycle: it clears `out_err`, discards the buffered words, and returns the output to idle. Centring then repeats, and consecutive words flow in order afterwards.
- R8: When `sel_refclk`=1 and `rate_half`=0, words are captured on `clk_char`. The word captured at one edge is on `out_char` after the next edge. The result does not depend on `clk_tx`, which may be stopped.
- R9: In the bypass setting of R8, `out_err` stays 0 and `recentre` has no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | External transmit clock (buffered mode) |
| clk_char | input | 1 | Internal character clock, also the full-rate reference |
| rst | input | 1 | Synchronous active-high reset, held over several edges of both clocks |
| sel_refclk | input | 1 | 1 selects the reference clock for the input register |
| rate_half | input | 1 | 1 marks the reference as not full rate (forces buffered path) |
| enc_off | input | 1 | 1 = word is a pre-encoded 10-bit character |
| recentre | input | 1 | Pulse (clk_char domain): clear error and recentre the FIFO |
| tx_data | input | 8 | Data byte to capture |
| tx_ctl | input | 2 | Control field to capture |
| out_char | output | 10 | Delivered word {control, data} or idle character |
| out_live | output | 1 | 1 when `out_char` carries a captured word |
| out_raw | output | 1 | Registered copy of `enc_off` |
| out_err | output | 1 | Sticky FIFO overflow/underflow flag |

## Verification
The assertions take the path-select inputs and `enc_off` as static between resets. They take `recentre` and the inputs of the selected capture clock as synchronous to that clock, and in bypass they read the input word two character edges back. The stimulus changes the mode only while `rst` is high. It drives the word inputs on the falling edge of whichever clock captures them and pulses `recentre` for exactly one character cycle. It creates underflow and overflow only by stopping one clock outright, never by changing its frequency, so the single-bit Gray steps and the pointer arithmetic stay within their assumptions.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

    localparam int DATA_W = 8;
    localparam int CTL_W  = 2;
    localparam int CHAR_W = DATA_W + CTL_W;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] data;
    } char_t;

    localparam char_t IDLE_CHAR = '{ctl: 2'b01, data: 8'h7C};

    typedef enum logic {
        RD_WAIT = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    typedef enum logic {
        PATH_BUFFERED = 1'b0,
        PATH_BYPASS   = 1'b1
    } path_e;

    function automatic path_e pick_path(input logic use_ref, input logic ref_half);
        return (use_ref && !ref_half) ? PATH_BYPASS : PATH_BUFFERED;
    endfunction

endpackage

// File: rtl/tpa_in_reg.sv
module tpa_in_reg
    import tpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  char_t d,
    output char_t q,
    output logic  vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= IDLE_CHAR;
            vld <= 1'b0;
        end else begin
            q   <= d;
            vld <= 1'b1;
        end
    end
endmodule

// File: rtl/tpa_sync.sv
module tpa_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tpa_fifo_wr.sv
module tpa_fifo_wr
    import tpa_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  char_t         wr_word,
    input  logic [AW-1:0] raddr,
    output char_t         rd_word,
    output logic [PW-1:0] wgray
);
    char_t         mem [DEPTH];
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;

    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) mem[wbin[AW-1:0]] <= wr_word;
    end

    assign rd_word = mem[raddr];

    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1)
        else $error("gray pointer moved by more than one bit"); // R3

endmodule

// File: rtl/tpa_fifo_rd.sv
module tpa_fifo_rd
    import tpa_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CENTRE = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          recentre,
    input  logic [PW-1:0] wgray_s,
    input  char_t         rd_word,
    output logic [AW-1:0] raddr,
    output char_t         o_char,
    output logic          o_live,
    output logic          o_err
);
    localparam logic [PW-1:0] CENTRE_C = PW'(CENTRE);
    localparam logic [PW-1:0] DEPTH_C  = PW'(DEPTH);

    rd_state_e     st;
    logic [PW-1:0] rptr;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] count;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign count = wbin_s - rptr;
    assign raddr = rptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RD_WAIT;
            rptr   <= '0;
            o_char <= IDLE_CHAR;
            o_live <= 1'b0;
            o_err  <= 1'b0;
        end else if (recentre) begin
            st     <= RD_WAIT;
            rptr   <= wbin_s;
            o_char <= IDLE_CHAR;
            o_live <= 1'b0;
            o_err  <= 1'b0;
        end else begin
            case (st)
                RD_WAIT: begin
                    o_char <= IDLE_CHAR;
                    o_live <= 1'b0;
                    if (count >= CENTRE_C) st <= RD_RUN;
                end
                default: begin
                    if (count == '0) begin
                        o_char <= IDLE_CHAR;
                        o_live <= 1'b0;
                        o_err  <= 1'b1;
                    end else begin
                        o_char <= rd_word;
                        o_live <= 1'b1;
                        rptr   <= rptr + PW'(1);
                        if (count > DEPTH_C) o_err <= 1'b1;
                    end
                end
            endcase
        end
    end

    AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == RD_WAIT) |=> !o_live)
        else $error("live output while centring"); // R4
    AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (st == RD_RUN && count == '0 && !recentre) |=> (!o_live && o_err))
        else $error("read from empty buffer"); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (o_err && !recentre) |=> o_err)
        else $error("error flag dropped without recentre"); // R6
    AST_RECENTRE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        recentre |=> (!o_err && !o_live))
        else $error("recentre did not clear state"); // R7

endmodule

// File: rtl/tx_phase_align.sv
module tx_phase_align
    import tpa_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int CENTRE      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_tx,
    input  logic              clk_char,
    input  logic              rst,
    input  logic              sel_refclk,
    input  logic              rate_half,
    input  logic              enc_off,
    input  logic              recentre,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [CTL_W-1:0]  tx_ctl,
    output logic [CHAR_W-1:0] out_char,
    output logic              out_live,
    output logic              out_raw,
    output logic              out_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    path_e path;
    logic  byp;
    logic  rst_fifo;
    logic  rst_cap_ch;
    char_t in_word;

    assign path       = pick_path(sel_refclk, rate_half);
    assign byp        = (path == PATH_BYPASS);
    assign rst_fifo   = rst | byp;
    assign rst_cap_ch = rst | !byp;
    assign in_word    = '{ctl: tx_ctl, data: tx_data};

    char_t         cap_tx_q, cap_ch_q;
    logic          cap_tx_vld, cap_ch_vld;
    char_t         fifo_rd_word, fifo_char;
    logic [AW-1:0] fifo_raddr;
    logic [PW-1:0] wgray, wgray_s;
    logic          fifo_live, fifo_err;
    char_t         byp_q;
    logic          byp_live;

    tpa_in_reg u_cap_tx (
        .clk (clk_tx),   .rst (rst_fifo),   .d (in_word), .q (cap_tx_q), .vld (cap_tx_vld)
    );
    tpa_in_reg u_cap_ch (
        .clk (clk_char), .rst (rst_cap_ch), .d (in_word), .q (cap_ch_q), .vld (cap_ch_vld)
    );

    tpa_fifo_wr #(.DEPTH(DEPTH)) u_wr (
        .clk     (clk_tx),
        .rst     (rst_fifo),
        .wr_en   (cap_tx_vld),
        .wr_word (cap_tx_q),
        .raddr   (fifo_raddr),
        .rd_word (fifo_rd_word),
        .wgray   (wgray)
    );

    tpa_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_char), .rst (rst_fifo), .d (wgray), .q (wgray_s)
    );

    tpa_fifo_rd #(.DEPTH(DEPTH), .CENTRE(CENTRE)) u_rd (
        .clk      (clk_char),
        .rst      (rst_fifo),
        .recentre (recentre),
        .wgray_s  (wgray_s),
        .rd_word  (fifo_rd_word),
        .raddr    (fifo_raddr),
        .o_char   (fifo_char),
        .o_live   (fifo_live),
        .o_err    (fifo_err)
    );

    always_ff @(posedge clk_char) begin
        if (rst_cap_ch) begin
            byp_q    <= IDLE_CHAR;
            byp_live <= 1'b0;
        end else begin
            byp_q    <= cap_ch_q;
            byp_live <= cap_ch_vld;
        end
    end

    always_ff @(posedge clk_char) begin
        if (rst) out_raw <= 1'b0;
        else     out_raw <= enc_off;
    end

    assign out_char = byp ? byp_q    : fifo_char;
    assign out_live = byp ? byp_live : fifo_live;
    assign out_err  = byp ? 1'b0     : fifo_err;

    AST_BYPASS_LATENCY: assert property (@(posedge clk_char) disable iff (rst)
        (byp && out_live) |-> (out_char == $past({tx_ctl, tx_data}, 2)))
        else $error("bypass latency broken"); // R8
    AST_BYPASS_QUIET: assert property (@(posedge clk_char) disable iff (rst)
        byp |-> !fifo_err)
        else $error("buffer error while bypassed"); // R9

endmodule

// File: tb/tx_phase_align_test.sv
`timescale 1ns/100ps
module tx_phase_align_test;

    localparam logic [9:0] IDLE = 10'h17C;

    logic clk_tx = 1'b0, clk_char = 1'b0;
    logic tx_en = 1'b1, ch_en = 1'b1;
    logic rst = 1'b1, sel_refclk = 1'b0, rate_half = 1'b0, enc_off = 1'b0, recentre = 1'b0;
    logic [9:0] seq_t = '0, seq_c = '0;
    logic live_t = 1'b0, live_c = 1'b0;
    logic [9:0] out_char;
    logic out_live, out_raw, out_err;
    logic [9:0] in_word;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    initial forever begin #2;   if (ch_en) clk_char = ~clk_char; end
    initial begin #1.3; forever begin #2; if (tx_en) clk_tx = ~clk_tx; end end

    always @(posedge clk_tx)   live_t <= !rst;
    always @(negedge clk_tx)   seq_t  <= live_t ? seq_t + 10'd1 : 10'd0;
    always @(posedge clk_char) live_c <= !rst;
    always @(negedge clk_char) seq_c  <= live_c ? seq_c + 10'd1 : 10'd0;

    assign in_word = (sel_refclk && !rate_half) ? seq_c : seq_t;

    tx_phase_align uut (
        .clk_tx (clk_tx), .clk_char (clk_char), .rst (rst),
        .sel_refclk (sel_refclk), .rate_half (rate_half), .enc_off (enc_off),
        .recentre (recentre), .tx_data (in_word[7:0]), .tx_ctl (in_word[9:8]),
        .out_char (out_char), .out_live (out_live), .out_raw (out_raw), .out_err (out_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s, input logic h, input logic e);
        rst = 1'b1; sel_refclk = s; rate_half = h; enc_off = e;
        repeat (4) @(negedge clk_char);
        chk(!out_live, "R1 live in reset", out_live, 0);
        chk(!out_err,  "R1 err in reset",  out_err, 0);
        chk(out_char == IDLE, "R1 idle in reset", out_char, IDLE);
        rst = 1'b0;
    endtask

    task automatic pulse_recentre();
        @(negedge clk_char); recentre = 1'b1;
        @(negedge clk_char); recentre = 1'b0;
        chk(!out_err,  "R7 err cleared", out_err, 0);
        chk(!out_live, "R7 output flushed", out_live, 0);
    endtask

    task automatic stream(input int n, input bit zero_first, input string tag);
        logic [9:0] prev;
        int waited = 0;
        while (!out_live && waited < 30) begin
            chk(out_char == IDLE, "R4 idle while centring", out_char, IDLE);
            @(negedge clk_char);
            waited++;
        end
        chk(out_live, "R4 centring completes", out_live, 1);
        prev = out_char;
        if (zero_first) chk(prev == 10'd0, "R4 first word after reset", prev, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_char);
            chk(out_live && out_char == prev + 10'd1, tag, out_char, prev + 10'd1);
            if (out_char >= 10'h100 && out_char < 10'h200)
                chk(out_char[9:8] == 2'b01, "R2 control field position", out_char[9:8], 1);
            prev = out_char;
        end
        chk(!out_err, {tag, " no error"}, out_err, 0);
    endtask

    initial begin
        // buffered, encoder enabled
        do_reset(1'b0, 1'b0, 1'b0);
        stream(300, 1'b1, "R3 in-order delivery");
        chk(out_raw == 1'b0, "R2 raw flag low", out_raw, 0);

        // underflow: stop transmit clock
        tx_en = 1'b0;
        repeat (12) @(negedge clk_char);
        chk(out_err,   "R5 underflow flagged", out_err, 1);
        chk(!out_live, "R5 live dropped", out_live, 0);
        tx_en = 1'b1;
        repeat (10) @(negedge clk_char);
        chk(out_err, "R5 error sticky", out_err, 1);
        pulse_recentre();
        stream(100, 1'b0, "R7 delivery after recentre");

        // overflow: stop character clock
        @(negedge clk_char);
        ch_en = 1'b0;
        repeat (9) @(negedge clk_tx);
        ch_en = 1'b1;
        repeat (10) @(negedge clk_char);
        chk(out_err, "R6 overflow flagged", out_err, 1);
        repeat (5) @(negedge clk_char);
        chk(out_err, "R6 error sticky", out_err, 1);
        pulse_recentre();
        stream(50, 1'b0, "R7 delivery after overflow recentre");

        // buffered via half-rate reference, encoder bypassed
        do_reset(1'b1, 1'b1, 1'b1);
        stream(40, 1'b1, "R3 half-rate selects buffer");
        chk(out_raw == 1'b1, "R2 raw flag high", out_raw, 1);

        // bypass with transmit clock stopped
        tx_en = 1'b0;
        do_reset(1'b1, 1'b0, 1'b0);
        @(negedge clk_char);
        @(negedge clk_char);
        chk(out_live, "R8 live after one capture", out_live, 1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk_char);
            chk(out_live && out_char == seq_c - 10'd1, "R8 one-cycle latency", out_char, seq_c - 10'd1);
            chk(!out_err, "R9 no error in bypass", out_err, 0);
            if (i == 100) recentre = 1'b1;
            if (i == 101) recentre = 1'b0;
        end
        chk(out_raw == 1'b0, "R2 raw flag follows mode", out_raw, 0);
        tx_en = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule